// File: doc/BRIEF.md
# Fault Status and Escalation Unit

This block sits beside a processor pipeline and turns its fault strobes into sticky cause bits and exception requests. Each cycle the pipeline may report memory-protection, bus and usage causes. Precise data faults also carry the faulting address. The unit records every cause in a 32-bit status word whose bits are cleared by writing one. It keeps the address of the newest precise data fault of each kind, together with a valid bit. It then requests the exception of the fault's own class, or escalates to a hard fault.

A fault escalates when its class handler is disabled, or when a handler of equal or higher rank is already running. Ranks, from low to high, are usage, bus, memory-protection and hard. A bus error during a vector table fetch goes straight to a hard fault. Any fault raised while the hard fault handler runs sets a lockup flag, and from then on no request is raised.

Software reads and clears the registers over a small register bus with byte enables. Register index 0 is the status word, 1 the memory-protection fault address, 2 the bus fault address and 3 the hard fault status word.

Top module: `fault_escalator`

## Requirements
- R1: After reset, every register reads zero and the outputs `req_mem`, `req_bus`, `req_usg`, `req_hard` and `lockup` are low.
- R2: Memory-protection causes set status bits on the edge that samples them: `mm_evt[0]` (instruction access) sets bit 0, `mm_evt[1]` (data access) sets bit 1 and the valid bit 7, `mm_evt[2]` (unstacking) sets bit 3, and `mm_evt[3]` (stacking) sets bit 4. Bits 2, 5 and 6 always read zero.
- R3: Bus causes set status bits: `bus_evt[0]` (fetch) sets bit 8, `bus_evt[1]` (precise data) sets bit 9 and the valid bit 15, `bus_evt[2]` (imprecise data) sets bit 10, `bus_evt[3]` (unstacking) sets bit 11, and `bus_evt[4]` (stacking) sets bit 12.
- R4: Usage causes fill the upper halfword: `usg_evt[0]` (undefined opcode) sets bit 16, `usg_evt[1]` (invalid state) bit 17, `usg_evt[2]` (bad exception return) bit 18, `usg_evt[3]` (coprocessor) bit 19. Unaligned access sets bit 24 and divide by zero sets bit 25.
- R5: A write to index 0 or 3 clears every bit whose `reg_wdata` bit is 1 inside an enabled byte lane. Zero bits and disabled lanes leave the bits unchanged. Writes to index 1 and 2 have no effect.
- R6: A read presents the selected register on `reg_rdata` one cycle after the request, with disabled byte lanes zero. In a cycle after no read, `reg_rdata` is zero.
- R7: `div_zero` records bit 25 and counts as a usage fault only when `trap_div0_en` is 1. `unal_single` does so for bit 24 only when `trap_unal_en` is 1. `unal_multi` always records bit 24 and faults.
- R8: A precise data fault (`mm_evt[1]` or `bus_evt[1]`) loads its address into register 1 or 2, and the newest fault overwrites an older one. Clearing a valid bit leaves the stored address unchanged. An imprecise bus error loads no address.
- R9: One cycle after a fault of a class, that class's request output pulses high for one cycle. This happens when the class handler enable is 1 and `act_cls` ranks lower than the class (0 thread, 1 usage, 2 bus, 3 memory-protection, 4 or more hard).
- R10: A fault whose class handler is disabled, or whose rank is not above `act_cls`, raises `req_hard` instead and sets hard status bit 30.
- R11: `vec_fetch_err` raises `req_hard` and sets hard status bit 1. `dbg_halt_evt` sets hard status bit 31 without any request. Hard status bits are cleared by writing 1.
- R12: A fault of any kind (including `vec_fetch_err`) while `act_cls` is 4 or more sets `lockup`, which stays high until reset. From that cycle on no request is raised and bit 30 is not set, while cause bits are still recorded.
- R13: When a clearing write and a new fault hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_evt | input | 4 | Memory-protection cause strobes: stacking, unstacking, data, instruction (bit 3 down to 0) |
| mm_fault_addr | input | ADDR_W | Address of a memory-protection data fault |
| bus_evt | input | 5 | Bus cause strobes: stacking, unstacking, imprecise, precise, fetch (bit 4 down to 0) |
| bus_fault_addr | input | ADDR_W | Address of a precise bus data fault |
| usg_evt | input | 4 | Usage strobes: coprocessor, bad return, invalid state, undefined (bit 3 down to 0) |
| unal_single | input | 1 | Unaligned single access seen |
| unal_multi | input | 1 | Unaligned multiple load or store seen |
| div_zero | input | 1 | Division by zero seen |
| vec_fetch_err | input | 1 | Bus error on a vector table fetch |
| dbg_halt_evt | input | 1 | Debug event |
| hnd_en_mem | input | 1 | Memory-protection handler enabled |
| hnd_en_bus | input | 1 | Bus fault handler enabled |
| hnd_en_usg | input | 1 | Usage fault handler enabled |
| trap_div0_en | input | 1 | Divide-by-zero trapping enabled |
| trap_unal_en | input | 1 | Unaligned single-access trapping enabled |
| act_cls | input | 3 | Rank of the running handler |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_idx | input | 2 | Register index |
| reg_be | input | 4 | Byte lane enables |
| reg_wdata | input | 32 | Write data (ones clear) |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| req_mem | output | 1 | Memory-protection exception request |
| req_bus | output | 1 | Bus fault exception request |
| req_usg | output | 1 | Usage fault exception request |
| req_hard | output | 1 | Hard fault exception request |
| lockup | output | 1 | Lockup flag |

## Verification
Every result of this block lands on the first rising edge after its stimulus. Requests, lockup and status bits change on the edge that samples the strobe, and read data appears on the edge after the read request. The bench drives inputs at falling edges and compares at the next falling edge, after exactly one rising edge. Status contents are observed through a read issued in the following cycle, so their expected values are taken one cycle after the event that set them. A reference model in the bench advances on the same edge and predicts the requests, lockup and read data for every cycle.

// File: rtl/fltesc_pkg.sv
package fltesc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned N_CLS  = 3;

  // class slots; slot g carries rank g+1
  localparam int unsigned CLS_USG = 0;
  localparam int unsigned CLS_BUS = 1;
  localparam int unsigned CLS_MEM = 2;

  localparam logic [2:0] ACT_HARD = 3'd4;

  // status word bit positions
  localparam int unsigned MB_IACC   = 0;
  localparam int unsigned MB_DACC   = 1;
  localparam int unsigned MB_UNSTK  = 3;
  localparam int unsigned MB_STK    = 4;
  localparam int unsigned MB_AVALID = 7;
  localparam int unsigned BB_BASE   = 8;
  localparam int unsigned BB_PREC   = 9;
  localparam int unsigned BB_AVALID = 15;
  localparam int unsigned UB_BASE   = 16;
  localparam int unsigned UB_UNAL   = 24;
  localparam int unsigned UB_DIV0   = 25;
  localparam logic [WORD_W-1:0] STAT_IMPL = 32'h030F_9F9B;

  // hard status word bit positions
  localparam int unsigned HB_VECT   = 1;
  localparam int unsigned HB_FORCED = 30;
  localparam int unsigned HB_DEBUG  = 31;
  localparam logic [WORD_W-1:0] HARD_IMPL = 32'hC000_0002;

  localparam logic [1:0] IDX_STATUS  = 2'd0;
  localparam logic [1:0] IDX_MMADDR  = 2'd1;
  localparam logic [1:0] IDX_BUSADDR = 2'd2;
  localparam logic [1:0] IDX_HARD    = 2'd3;

  typedef struct packed {
    logic hard;
    logic mem;
    logic bus;
    logic usg;
  } req_t;

endpackage

// File: rtl/fltesc_router.sv
module fltesc_router
  import fltesc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mm_evt,
  input  logic [4:0]        bus_evt,
  input  logic [3:0]        usg_evt,
  input  logic              unal_single,
  input  logic              unal_multi,
  input  logic              div_zero,
  input  logic              vec_fetch_err,
  input  logic              dbg_halt_evt,
  input  logic              hnd_en_mem,
  input  logic              hnd_en_bus,
  input  logic              hnd_en_usg,
  input  logic              trap_div0_en,
  input  logic              trap_unal_en,
  input  logic [2:0]        act_cls,
  output logic [WORD_W-1:0] stat_set,
  output logic [WORD_W-1:0] hard_set,
  output logic              mm_cap,
  output logic              bus_cap,
  output req_t              req_q,
  output logic              lock_q
);

  logic [N_CLS-1:0] cls_any;
  logic [N_CLS-1:0] cls_en;
  logic [N_CLS-1:0] cls_esc;
  logic [2:0]       act_rank;
  logic             lock_hit;
  logic             frozen;
  req_t             req_d;

  // cause bits gathered into the status word layout
  always_comb begin
    stat_set                   = '0;
    stat_set[MB_IACC]          = mm_evt[0];
    stat_set[MB_DACC]          = mm_evt[1];
    stat_set[MB_UNSTK]         = mm_evt[2];
    stat_set[MB_STK]           = mm_evt[3];
    stat_set[MB_AVALID]        = mm_evt[1];
    stat_set[BB_BASE +: 5]     = bus_evt;
    stat_set[BB_AVALID]        = bus_evt[1];
    stat_set[UB_BASE +: 4]     = usg_evt;
    stat_set[UB_UNAL]          = unal_multi | (unal_single & trap_unal_en);
    stat_set[UB_DIV0]          = div_zero & trap_div0_en;
  end

  assign mm_cap  = mm_evt[1];
  assign bus_cap = bus_evt[1];

  assign cls_any[CLS_MEM] = |mm_evt;
  assign cls_any[CLS_BUS] = |bus_evt;
  assign cls_any[CLS_USG] = |stat_set[UB_DIV0:UB_BASE];
  assign cls_en[CLS_MEM]  = hnd_en_mem;
  assign cls_en[CLS_BUS]  = hnd_en_bus;
  assign cls_en[CLS_USG]  = hnd_en_usg;

  assign act_rank = (act_cls > ACT_HARD) ? ACT_HARD : act_cls;

  generate
    for (genvar g = 0; g < N_CLS; g++) begin : g_cls
      localparam logic [2:0] RANK = 3'(g + 1);
      assign cls_esc[g] = cls_any[g] & (~cls_en[g] | (act_rank >= RANK));
    end
  endgenerate

  assign lock_hit = (act_rank == ACT_HARD) & ((|cls_any) | vec_fetch_err);
  assign frozen   = lock_hit | lock_q;

  always_comb begin
    hard_set            = '0;
    hard_set[HB_VECT]   = vec_fetch_err;
    hard_set[HB_FORCED] = (|cls_esc) & ~frozen;
    hard_set[HB_DEBUG]  = dbg_halt_evt;
  end

  always_comb begin
    req_d.mem  = cls_any[CLS_MEM] & ~cls_esc[CLS_MEM] & ~frozen;
    req_d.bus  = cls_any[CLS_BUS] & ~cls_esc[CLS_BUS] & ~frozen;
    req_d.usg  = cls_any[CLS_USG] & ~cls_esc[CLS_USG] & ~frozen;
    req_d.hard = ((|cls_esc) | vec_fetch_err) & ~frozen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_hit) begin
      lock_q <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q); // R12

endmodule

// File: rtl/fltesc_addr_cap.sv
module fltesc_addr_cap #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] addr_d;

  assign addr_d = addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cap) begin
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/fltesc_status.sv
module fltesc_status
  import fltesc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] stat_set,
  input  logic [WORD_W-1:0] hard_set,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_idx,
  input  logic [LANES-1:0]  reg_be,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] hard_q,
  output logic [WORD_W-1:0] reg_rdata
);

  logic [WORD_W-1:0] lane_mask;
  logic              wr_stat;
  logic              wr_hard;
  logic [WORD_W-1:0] clr_stat;
  logic [WORD_W-1:0] clr_hard;
  logic [WORD_W-1:0] stat_d;
  logic [WORD_W-1:0] hard_d;
  logic              stat_ce;
  logic              hard_ce;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rd_d;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[8*g +: 8] = {8{reg_be[g]}};
    end
  endgenerate

  assign wr_stat  = reg_en & reg_wr & (reg_idx == IDX_STATUS);
  assign wr_hard  = reg_en & reg_wr & (reg_idx == IDX_HARD);
  assign clr_stat = wr_stat ? (reg_wdata & lane_mask) : '0;
  assign clr_hard = wr_hard ? (reg_wdata & lane_mask) : '0;

  // a new event is ORed in after the clear, so it wins
  assign stat_d  = ((stat_q & ~clr_stat) | stat_set) & STAT_IMPL;
  assign hard_d  = ((hard_q & ~clr_hard) | hard_set) & HARD_IMPL;
  assign stat_ce = wr_stat | (|stat_set);
  assign hard_ce = wr_hard | (|hard_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_q <= '0;
    end else if (hard_ce) begin
      hard_q <= hard_d;
    end
  end

  always_comb begin
    case (reg_idx)
      IDX_STATUS:  rd_word = stat_q;
      IDX_MMADDR:  rd_word = WORD_W'(mm_addr);
      IDX_BUSADDR: rd_word = WORD_W'(bus_addr);
      default:     rd_word = hard_q;
    endcase
  end

  assign rd_d = (reg_en & ~reg_wr) ? (rd_word & lane_mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_d;
    end
  end

  AST_STAT_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_q) & ~stat_q)) |-> $past(wr_stat)); // R5

  AST_HARD_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(hard_q) & ~hard_q)) |-> $past(wr_hard)); // R11

endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fltesc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mm_evt,
  input  logic [ADDR_W-1:0] mm_fault_addr,
  input  logic [4:0]        bus_evt,
  input  logic [ADDR_W-1:0] bus_fault_addr,
  input  logic [3:0]        usg_evt,
  input  logic              unal_single,
  input  logic              unal_multi,
  input  logic              div_zero,
  input  logic              vec_fetch_err,
  input  logic              dbg_halt_evt,
  input  logic              hnd_en_mem,
  input  logic              hnd_en_bus,
  input  logic              hnd_en_usg,
  input  logic              trap_div0_en,
  input  logic              trap_unal_en,
  input  logic [2:0]        act_cls,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_idx,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_mem,
  output logic              req_bus,
  output logic              req_usg,
  output logic              req_hard,
  output logic              lockup
);

  logic [WORD_W-1:0] stat_set;
  logic [WORD_W-1:0] hard_set;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] hard_q;
  logic              mm_cap;
  logic              bus_cap;
  logic [ADDR_W-1:0] mm_addr_q;
  logic [ADDR_W-1:0] bus_addr_q;
  req_t              req_q;
  logic              lock_q;

  fltesc_router i_router (
    .clk           (clk),
    .rst_n         (rst_n),
    .mm_evt        (mm_evt),
    .bus_evt       (bus_evt),
    .usg_evt       (usg_evt),
    .unal_single   (unal_single),
    .unal_multi    (unal_multi),
    .div_zero      (div_zero),
    .vec_fetch_err (vec_fetch_err),
    .dbg_halt_evt  (dbg_halt_evt),
    .hnd_en_mem    (hnd_en_mem),
    .hnd_en_bus    (hnd_en_bus),
    .hnd_en_usg    (hnd_en_usg),
    .trap_div0_en  (trap_div0_en),
    .trap_unal_en  (trap_unal_en),
    .act_cls       (act_cls),
    .stat_set      (stat_set),
    .hard_set      (hard_set),
    .mm_cap        (mm_cap),
    .bus_cap       (bus_cap),
    .req_q         (req_q),
    .lock_q        (lock_q)
  );

  fltesc_addr_cap #(.ADDR_W(ADDR_W)) i_mm_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (mm_cap),
    .addr_in (mm_fault_addr),
    .addr_q  (mm_addr_q)
  );

  fltesc_addr_cap #(.ADDR_W(ADDR_W)) i_bus_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (bus_cap),
    .addr_in (bus_fault_addr),
    .addr_q  (bus_addr_q)
  );

  fltesc_status #(.ADDR_W(ADDR_W)) i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_set  (stat_set),
    .hard_set  (hard_set),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .mm_addr   (mm_addr_q),
    .bus_addr  (bus_addr_q),
    .stat_q    (stat_q),
    .hard_q    (hard_q),
    .reg_rdata (reg_rdata)
  );

  assign req_mem  = req_q.mem;
  assign req_bus  = req_q.bus;
  assign req_usg  = req_q.usg;
  assign req_hard = req_q.hard;
  assign lockup   = lock_q;

  AST_LOCK_SILENCES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> !(req_mem | req_bus | req_usg | req_hard)); // R12

  AST_HARD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_hard |-> (hard_q[HB_FORCED] | hard_q[HB_VECT])); // R10

  AST_DIV0_NEEDS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[UB_DIV0]) |-> $past(trap_div0_en)); // R7

  AST_MM_ADDR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mm_evt[1]) |-> (mm_addr_q == $past(mm_fault_addr))); // R8

  AST_BUS_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_evt[1]) |-> $stable(bus_addr_q)); // R8

  AST_REQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mem | req_bus | req_usg | req_hard) |->
      $past((|mm_evt) | (|bus_evt) | (|usg_evt) | unal_single | unal_multi
            | div_zero | vec_fetch_err)); // R9

endmodule

// File: tb/test_fault_escalator.sv
module test_fault_escalator;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mm_evt;
  logic [31:0] mm_fault_addr;
  logic [4:0]  bus_evt;
  logic [31:0] bus_fault_addr;
  logic [3:0]  usg_evt;
  logic        unal_single, unal_multi, div_zero, vec_fetch_err, dbg_halt_evt;
  logic        hnd_en_mem, hnd_en_bus, hnd_en_usg, trap_div0_en, trap_unal_en;
  logic [2:0]  act_cls;
  logic        reg_en, reg_wr;
  logic [1:0]  reg_idx;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_mem, req_bus, req_usg, req_hard, lockup;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_stat, m_hf, m_mma, m_mba;
  logic        m_lock;
  logic [31:0] e_rdata;
  logic [3:0]  e_req;   // {hard, mem, bus, usg}
  logic        e_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_escalator i_fault_escalator (
    .clk(clk), .rst_n(rst_n), .mm_evt(mm_evt), .mm_fault_addr(mm_fault_addr),
    .bus_evt(bus_evt), .bus_fault_addr(bus_fault_addr), .usg_evt(usg_evt),
    .unal_single(unal_single), .unal_multi(unal_multi), .div_zero(div_zero),
    .vec_fetch_err(vec_fetch_err), .dbg_halt_evt(dbg_halt_evt),
    .hnd_en_mem(hnd_en_mem), .hnd_en_bus(hnd_en_bus), .hnd_en_usg(hnd_en_usg),
    .trap_div0_en(trap_div0_en), .trap_unal_en(trap_unal_en), .act_cls(act_cls),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_mem(req_mem),
    .req_bus(req_bus), .req_usg(req_usg), .req_hard(req_hard), .lockup(lockup)
  );

  function automatic logic [31:0] bemask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] bm, sset, hset, clr0, clr3, rdv;
    logic [2:0]  ar;
    logic        a_m, a_b, a_u, x_m, x_b, x_u, lh, fz;
    if (!rst_n) begin
      m_stat = 0; m_hf = 0; m_mma = 0; m_mba = 0; m_lock = 0;
      e_rdata = 0; e_req = 0; e_lock = 0;
      return;
    end
    bm = bemask(reg_be);
    case (reg_idx)
      2'd0: rdv = m_stat;
      2'd1: rdv = m_mma;
      2'd2: rdv = m_mba;
      default: rdv = m_hf;
    endcase
    e_rdata = (reg_en && !reg_wr) ? (rdv & bm) : 32'h0;
    sset = 0;
    sset[0] = mm_evt[0]; sset[1] = mm_evt[1]; sset[3] = mm_evt[2];
    sset[4] = mm_evt[3]; sset[7] = mm_evt[1];
    sset[12:8] = bus_evt; sset[15] = bus_evt[1];
    sset[19:16] = usg_evt;
    sset[24] = unal_multi | (unal_single & trap_unal_en);
    sset[25] = div_zero & trap_div0_en;
    a_m = |mm_evt; a_b = |bus_evt; a_u = |sset[25:16];
    ar = (act_cls > 3'd4) ? 3'd4 : act_cls;
    x_m = a_m & (!hnd_en_mem || ar >= 3'd3);
    x_b = a_b & (!hnd_en_bus || ar >= 3'd2);
    x_u = a_u & (!hnd_en_usg || ar >= 3'd1);
    lh = (ar == 3'd4) & (a_m | a_b | a_u | vec_fetch_err);
    fz = lh | m_lock;
    hset = 0;
    hset[1] = vec_fetch_err;
    hset[30] = (x_m | x_b | x_u) & !fz;
    hset[31] = dbg_halt_evt;
    e_req = fz ? 4'b0 : {(x_m | x_b | x_u | vec_fetch_err), a_m & !x_m, a_b & !x_b, a_u & !x_u};
    clr0 = (reg_en && reg_wr && reg_idx == 2'd0) ? (reg_wdata & bm) : 32'h0;
    clr3 = (reg_en && reg_wr && reg_idx == 2'd3) ? (reg_wdata & bm) : 32'h0;
    m_stat = (m_stat & ~clr0) | sset;
    m_hf = (m_hf & ~clr3) | hset;
    if (mm_evt[1]) m_mma = mm_fault_addr;
    if (bus_evt[1]) m_mba = bus_fault_addr;
    m_lock = m_lock | lh;
    e_lock = m_lock;
  endtask

  // one clock: model follows the rising edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R6 rdata", reg_rdata, e_rdata);
    chk("R9 class requests", {29'b0, req_mem, req_bus, req_usg}, {29'b0, e_req[2:0]});
    chk("R10 req_hard", {31'b0, req_hard}, {31'b0, e_req[3]});
    chk("R12 lockup", {31'b0, lockup}, {31'b0, e_lock});
  endtask

  task automatic idle();
    mm_evt = 0; bus_evt = 0; usg_evt = 0; unal_single = 0; unal_multi = 0;
    div_zero = 0; vec_fetch_err = 0; dbg_halt_evt = 0;
    reg_en = 0; reg_wr = 0; reg_idx = 0; reg_be = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] idx, input logic [3:0] be, output logic [31:0] d);
    reg_en = 1; reg_wr = 0; reg_idx = idx; reg_be = be;
    cyc();
    d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [3:0] be, input logic [31:0] d);
    reg_en = 1; reg_wr = 1; reg_idx = idx; reg_be = be; reg_wdata = d;
    cyc();
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic clear_all();
    wr(2'd0, 4'hF, 32'hFFFF_FFFF);
    wr(2'd3, 4'hF, 32'hFFFF_FFFF);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd24681));
    idle();
    mm_fault_addr = 0; bus_fault_addr = 0;
    hnd_en_mem = 1; hnd_en_bus = 1; hnd_en_usg = 1;
    trap_div0_en = 0; trap_unal_en = 0; act_cls = 0;
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), 4'hF, d);
      chk("R1 register after reset", d, 32'h0);
    end
    chk("R1 outputs after reset", {27'b0, req_mem, req_bus, req_usg, req_hard, lockup}, 32'h0);

    // R2 memory-protection causes, R8 capture, R9 request
    mm_evt = 4'hF; mm_fault_addr = 32'hA000_1000;
    cyc();
    chk("R9 req_mem after mm fault", {31'b0, req_mem}, 32'h1);
    idle();
    rd(2'd0, 4'h1, d);
    chk("R2 mm byte", d, 32'h0000_009B);
    rd(2'd1, 4'hF, d);
    chk("R8 mm address", d, 32'hA000_1000);

    // R3 bus causes
    bus_evt = 5'h1F; bus_fault_addr = 32'hB000_2000;
    cyc();
    chk("R9 req_bus after bus fault", {31'b0, req_bus}, 32'h1);
    idle();
    rd(2'd0, 4'h2, d);
    chk("R3 bus byte", d, 32'h0000_9F00);
    rd(2'd2, 4'hF, d);
    chk("R8 bus address", d, 32'hB000_2000);

    // R5 write-one-to-clear by lane
    wr(2'd0, 4'h1, 32'h0000_0002);
    rd(2'd0, 4'h1, d);
    chk("R5 clear dacc only", d, 32'h0000_0099);
    wr(2'd0, 4'hF, 32'h0);
    rd(2'd0, 4'hF, d);
    chk("R5 write zero keeps", d, 32'h0000_9F99);
    wr(2'd0, 4'h2, 32'hFFFF_FFFF);
    rd(2'd0, 4'hF, d);
    chk("R5 only bus lane cleared", d, 32'h0000_0099);
    wr(2'd1, 4'hF, 32'h1234_5678);
    rd(2'd1, 4'hF, d);
    chk("R5 address register not writable", d, 32'hA000_1000);

    // R8 valid clear keeps address; newest wins; imprecise loads nothing
    wr(2'd0, 4'h1, 32'h0000_0080);
    rd(2'd1, 4'hF, d);
    chk("R8 address kept after valid clear", d, 32'hA000_1000);
    mm_evt = 4'h2; mm_fault_addr = 32'hA000_3000;
    cyc(); idle();
    rd(2'd1, 4'hF, d);
    chk("R8 newest address", d, 32'hA000_3000);
    bus_evt = 5'h04; bus_fault_addr = 32'hDEAD_0000;
    cyc(); idle();
    rd(2'd2, 4'hF, d);
    chk("R8 imprecise no capture", d, 32'hB000_2000);

    // R4 usage causes, R6 lane masking
    clear_all();
    usg_evt = 4'hF;
    cyc();
    chk("R9 req_usg", {31'b0, req_usg}, 32'h1);
    idle();
    rd(2'd0, 4'hC, d);
    chk("R4 usage halfword", d, 32'h000F_0000);
    rd(2'd0, 4'h4, d);
    chk("R6 single lane read", d, 32'h000F_0000);
    cyc();
    chk("R6 no read gives zero", reg_rdata, 32'h0);

    // R7 trap gating
    clear_all();
    div_zero = 1; unal_single = 1;
    cyc();
    chk("R7 untrapped no request", {28'b0, req_usg, req_hard, req_mem, req_bus}, 32'h0);
    idle();
    rd(2'd0, 4'hF, d);
    chk("R7 untrapped not recorded", d, 32'h0);
    trap_div0_en = 1; trap_unal_en = 1;
    div_zero = 1; unal_single = 1;
    cyc(); idle();
    rd(2'd0, 4'h8, d);
    chk("R7 trapped recorded", d, 32'h0300_0000);
    clear_all();
    trap_unal_en = 0; unal_multi = 1;
    cyc();
    chk("R7 multi always faults", {31'b0, req_usg}, 32'h1);
    idle();
    rd(2'd0, 4'h8, d);
    chk("R7 multi recorded", d, 32'h0100_0000);

    // R10 escalation
    clear_all();
    hnd_en_bus = 0; bus_evt = 5'h01;
    cyc();
    chk("R10 disabled bus escalates", {30'b0, req_bus, req_hard}, 32'h1);
    idle(); hnd_en_bus = 1;
    rd(2'd3, 4'hF, d);
    chk("R10 forced bit", d, 32'h4000_0000);
    clear_all();
    act_cls = 3'd2; bus_evt = 5'h01;
    cyc();
    chk("R10 equal rank escalates", {30'b0, req_bus, req_hard}, 32'h1);
    act_cls = 3'd3; bus_evt = 5'h01;
    cyc();
    chk("R10 higher rank escalates", {30'b0, req_bus, req_hard}, 32'h1);
    act_cls = 3'd1; bus_evt = 5'h01;
    cyc();
    chk("R9 lower rank requests", {30'b0, req_bus, req_hard}, 32'h2);
    idle(); act_cls = 0;

    // R11 vector fetch and debug
    clear_all();
    vec_fetch_err = 1;
    cyc();
    chk("R11 vector error hard request", {31'b0, req_hard}, 32'h1);
    idle();
    dbg_halt_evt = 1;
    cyc();
    chk("R11 debug no request", {28'b0, req_mem, req_bus, req_usg, req_hard}, 32'h0);
    idle();
    rd(2'd3, 4'hF, d);
    chk("R11 hard status bits", d, 32'h8000_0002);
    wr(2'd3, 4'h8, 32'h8000_0000);
    rd(2'd3, 4'hF, d);
    chk("R11 debug bit cleared", d, 32'h0000_0002);

    // R13 set wins over clear
    clear_all();
    bus_evt = 5'h01;
    reg_en = 1; reg_wr = 1; reg_idx = 2'd0; reg_be = 4'h2; reg_wdata = 32'h0000_FF00;
    cyc(); idle();
    rd(2'd0, 4'hF, d);
    chk("R13 set wins", d, 32'h0000_0100);

    // random phase, reference compared every cycle
    clear_all();
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom % 6 == 0) mm_evt = 4'($urandom);
      if ($urandom % 6 == 0) bus_evt = 5'($urandom);
      if ($urandom % 6 == 0) usg_evt = 4'($urandom);
      unal_single = ($urandom % 10 == 0);
      unal_multi = ($urandom % 14 == 0);
      div_zero = ($urandom % 10 == 0);
      vec_fetch_err = ($urandom % 25 == 0);
      dbg_halt_evt = ($urandom % 25 == 0);
      mm_fault_addr = $urandom; bus_fault_addr = $urandom;
      hnd_en_mem = ($urandom % 4 != 0); hnd_en_bus = ($urandom % 4 != 0);
      hnd_en_usg = ($urandom % 4 != 0);
      trap_div0_en = 1'($urandom); trap_unal_en = 1'($urandom);
      act_cls = 3'($urandom % 4);
      if ($urandom % 3 == 0) begin
        reg_en = 1; reg_wr = ($urandom % 3 == 0); reg_idx = 2'($urandom);
        reg_be = 4'($urandom); reg_wdata = $urandom;
      end
      cyc();
    end
    idle();
    act_cls = 0; hnd_en_mem = 1; hnd_en_bus = 1; hnd_en_usg = 1;
    clear_all();

    // R12 lockup
    act_cls = 3'd4; mm_evt = 4'h1;
    cyc();
    chk("R12 lockup set", {31'b0, lockup}, 32'h1);
    chk("R12 no request in lockup", {28'b0, req_mem, req_bus, req_usg, req_hard}, 32'h0);
    act_cls = 3'd0; mm_evt = 4'h1;
    cyc();
    chk("R12 still silent", {28'b0, req_mem, req_bus, req_usg, req_hard}, 32'h0);
    chk("R12 lockup held", {31'b0, lockup}, 32'h1);
    idle();
    rd(2'd0, 4'h1, d);
    chk("R12 cause still recorded", d, 32'h0000_0001);
    rd(2'd3, 4'hF, d);
    chk("R12 no forced bit", d, 32'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule